// File: doc/BRIEF.md
# Conversion-Done DMA Request Generator

This block turns per-group conversion-complete events into DMA request lines. Each trigger group has a DMA enable, a pending flag and a request output. A completion event on an enabled group sets the group's pending flag and raises its request. The flag stays set until software clears it by writing a 1 to it. The request drops according to a single global release rule.

In pulsed release the DMA engine's acknowledge alone withdraws the request. In latched release the request is held until two things have happened. First, an acknowledge has been received, and the block remembers it. Second, the group's pending flag has been cleared. The enables and pending flags share one control word. Enables sit at bit n and flags at bit 16+n. A write that carries zeros in the flag field updates the enables and leaves every pending flag untouched.

Top module: `dmareq_gen`

## Requirements
- R1: A write (`wr_en_i` high) loads the group enables from `wr_data_i[N_GRP-1:0]`, and they read back at `rd_data_o[n]` from the next cycle.
- R2: `done_i[n]` high on a group whose enable is 1 sets the pending flag at `rd_data_o[16+n]` and raises `dma_req_o[n]`, both visible in the cycle after the event.
- R3: `done_i[n]` on a group whose enable is 0 changes neither its flag nor its request.
- R4: A write with bit 16+n set clears pending flag n from the next cycle. A write with bit 16+n zero leaves flag n as it was.
- R5: When a completion event and a write-1-to-clear of the same flag share a cycle, the flag ends set.
- R6: With `pulse_mode_i` = 1 (pulsed release), a pending request drops in the cycle after `ack_i[n]` is high, whatever the flag holds.
- R7: With `pulse_mode_i` = 0 (latched release), a request stays high while its flag is set, even after an acknowledge. The acknowledge is remembered. The request drops one cycle after the first cycle in which an acknowledge has been seen (now or earlier) and the flag reads 0.
- R8: A completion event in the same cycle as an acknowledge keeps the request high. In latched release, any remembered acknowledge is discarded.
- R9: `ack_i[n]` while `dma_req_o[n]` is low has no effect on later behaviour.
- R10: Synchronous reset clears all enables, flags and requests.
- R11: Bits of `rd_data_o` outside the enable and flag fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_mode_i | input | 1 | Release rule: 1 pulsed, 0 latched |
| done_i | input | N_GRP | Per-group conversion-complete pulse |
| ack_i | input | N_GRP | Per-group acknowledge from the DMA engine |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word: enables at [N_GRP-1:0], write-1-to-clear flags at [16+N_GRP-1:16] |
| rd_data_o | output | 32 | Readback: enables and pending flags |
| dma_req_o | output | N_GRP | Per-group DMA request |

## Verification
A stale enable shows up at `rd_data_o` one cycle after the write. The next completion event then either raises a request it should not, or fails to raise one it should. A lost or stuck remembered acknowledge is invisible until the flag is cleared in latched release. The request then either drops one cycle too early, or stays up until another acknowledge arrives. The reference model is compared on every cycle, so both kinds of defect are caught in the cycle after they first appear at the ports.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
    localparam int WORD_W   = 32;
    localparam int FLAG_LSB = 16;
    localparam int MAX_GRP  = 16;

    typedef enum logic {
        REL_LATCHED = 1'b0,
        REL_PULSED  = 1'b1
    } rel_mode_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic ack;
    } grp_evt_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [MAX_GRP-1:0] en,
                                                    input logic [MAX_GRP-1:0] flg);
        return {flg, en};
    endfunction
endpackage

// File: rtl/dmareq_ctrl_reg.sv
module dmareq_ctrl_reg
    import dmareq_pkg::*;
#(
    parameter int N_GRP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [N_GRP-1:0]  en_o,
    output logic [N_GRP-1:0]  clr_o
);
    logic [N_GRP-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en_i)
            en_q <= wr_data_i[N_GRP-1:0];
    end

    assign en_o  = en_q;
    assign clr_o = wr_en_i ? wr_data_i[FLAG_LSB +: N_GRP] : '0;

    // R1
    en_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (en_o == $past(wr_data_i[N_GRP-1:0])));

    // R1
    en_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(en_o));
endmodule

// File: rtl/dmareq_chan.sv
module dmareq_chan
    import dmareq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rel_mode_e mode_i,
    input  logic      done_i,
    input  logic      en_i,
    input  logic      clr_i,
    input  logic      ack_i,
    output logic      flag_o,
    output logic      req_o
);
    grp_evt_t evt;
    logic flag_q, req_q, ack_seen_q;

    assign evt.set = done_i & en_i;
    assign evt.clr = clr_i;
    assign evt.ack = ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q     <= 1'b0;
            req_q      <= 1'b0;
            ack_seen_q <= 1'b0;
        end else begin
            if (evt.set)
                flag_q <= 1'b1;
            else if (evt.clr)
                flag_q <= 1'b0;

            if (evt.set) begin
                req_q      <= 1'b1;
                ack_seen_q <= 1'b0;
            end else if (req_q) begin
                if (mode_i == REL_PULSED) begin
                    if (evt.ack)
                        req_q <= 1'b0;
                    ack_seen_q <= 1'b0;
                end else if ((ack_seen_q || evt.ack) && !flag_q) begin
                    req_q      <= 1'b0;
                    ack_seen_q <= 1'b0;
                end else begin
                    ack_seen_q <= ack_seen_q || evt.ack;
                end
            end
        end
    end

    assign flag_o = flag_q;
    assign req_o  = req_q;

    // R2
    set_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && en_i) |=> (flag_o && req_o));

    // R3
    no_spurious_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_o && !(done_i && en_i)) |=> !req_o);

    // R4
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && en_i && clr_i) |=> flag_o);

    // R6
    pulsed_release_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i && !(done_i && en_i) && mode_i == REL_PULSED) |=> !req_o);

    // R7
    latched_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o && flag_o && mode_i == REL_LATCHED) |=> req_o);
endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen
    import dmareq_pkg::*;
#(
    parameter int N_GRP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_mode_i,
    input  logic [N_GRP-1:0]  done_i,
    input  logic [N_GRP-1:0]  ack_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [N_GRP-1:0]  dma_req_o
);
    logic [N_GRP-1:0] en_w, clr_w, flag_w;
    rel_mode_e        mode_w;

    assign mode_w = rel_mode_e'(pulse_mode_i);

    dmareq_ctrl_reg #(.N_GRP(N_GRP)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .en_o      (en_w),
        .clr_o     (clr_w)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_chan
        dmareq_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .mode_i (mode_w),
            .done_i (done_i[g]),
            .en_i   (en_w[g]),
            .clr_i  (clr_w[g]),
            .ack_i  (ack_i[g]),
            .flag_o (flag_w[g]),
            .req_o  (dma_req_o[g])
        );
    end

    assign rd_data_o = pack_word(MAX_GRP'(en_w), MAX_GRP'(flag_w));

    // R11
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[FLAG_LSB-1:N_GRP] == '0) && (rd_data_o[WORD_W-1:FLAG_LSB+N_GRP] == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data_o == '0 && dma_req_o == '0));
endmodule

// File: tb/sim_dmareq_gen.sv
module sim_dmareq_gen;
    localparam int G = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    logic [G-1:0] done = '0, ack = '0;
    logic wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic [G-1:0] req;

    int total = 0, bad = 0, cyc = 0;
    string phase = "R10";

    bit m_en[G], m_flag[G], m_req[G], m_ack[G];

    always #10 clk = ~clk;

    dmareq_gen #(.N_GRP(G)) u0 (
        .clk(clk), .rst(rst), .pulse_mode_i(mode), .done_i(done), .ack_i(ack),
        .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd), .dma_req_o(req)
    );

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        for (int n = 0; n < G; n++) begin
            w[n] = m_en[n];
            w[16+n] = m_flag[n];
        end
        return w;
    endfunction

    function automatic logic [G-1:0] m_reqv();
        logic [G-1:0] v;
        for (int n = 0; n < G; n++) v[n] = m_req[n];
        return v;
    endfunction

    // behavioural reference
    always @(posedge clk) begin
        for (int n = 0; n < G; n++) begin
            bit s, got;
            if (rst) begin
                m_en[n] = 0; m_flag[n] = 0; m_req[n] = 0; m_ack[n] = 0;
            end else begin
                s = done[n] && m_en[n];
                got = m_ack[n] || ack[n];
                if (s) begin
                    m_req[n] = 1; m_ack[n] = 0;
                end else if (m_req[n]) begin
                    if (mode) begin
                        if (ack[n]) m_req[n] = 0;
                        m_ack[n] = 0;
                    end else if (got && !m_flag[n]) begin
                        m_req[n] = 0; m_ack[n] = 0;
                    end else m_ack[n] = got;
                end
                if (s) m_flag[n] = 1;
                else if (wr && wd[16+n]) m_flag[n] = 0;
                if (wr) m_en[n] = wd[n];
            end
        end
    end

    always @(negedge clk) begin
        total++;
        if (rd !== m_word() || req !== m_reqv()) begin
            bad++;
            $display("FAIL %s model: rd=%h req=%h expected rd=%h req=%h",
                     phase, rd, req, m_word(), m_reqv());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic [G-1:0] d, logic [G-1:0] a, logic w, logic [31:0] data);
        done = d; ack = a; wr = w; wd = data;
        @(negedge clk);
        done = '0; ack = '0; wr = 1'b0; wd = '0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset rd", rd, 32'h0);
        chk("R10 reset req", {24'h0, req}, 32'h0);

        phase = "R1";
        step('0, '0, 1, 32'h0000_00A5);
        chk("R1 enables", rd, 32'h0000_00A5);

        phase = "R2";
        step(8'hFF, '0, 0, 0);
        chk("R2 R3 flags", rd, 32'h00A5_00A5);
        chk("R2 R3 req", {24'h0, req}, 32'hA5);

        phase = "R9";
        step('0, 8'h02, 0, 0);
        chk("R9 ack idle", {24'h0, req}, 32'hA5);

        phase = "R4";
        step('0, '0, 1, 32'h0001_00A5);
        chk("R4 w1c", rd, 32'h00A4_00A5);
        step('0, '0, 1, 32'h0000_00A5);
        chk("R4 zero keeps", rd, 32'h00A4_00A5);

        phase = "R7";
        step('0, 8'h01, 0, 0);
        chk("R7 flag clear then ack", {24'h0, req}, 32'hA4);
        step('0, 8'h04, 0, 0);
        chk("R7 ack holds while flag", {24'h0, req}, 32'hA4);
        step('0, '0, 1, 32'h0004_00A5);
        chk("R7 one cycle after clear", {24'h0, req}, 32'hA4);
        step('0, '0, 0, 0);
        chk("R7 released", {24'h0, req}, 32'hA0);

        phase = "R6";
        mode = 1'b1;
        step('0, 8'h20, 0, 0);
        chk("R6 pulsed release", {24'h0, req}, 32'h80);
        chk("R6 flag kept", rd, 32'h00A0_00A5);

        phase = "R5";
        step(8'h80, '0, 1, 32'h0080_00A5);
        chk("R5 set wins", rd, 32'h00A0_00A5);

        phase = "R8";
        step(8'h80, 8'h80, 0, 0);
        chk("R8 pulsed set+ack", {24'h0, req}, 32'h80);
        mode = 1'b0;
        step('0, 8'h80, 0, 0);
        step(8'h80, '0, 0, 0);
        step('0, '0, 1, 32'h0080_00A5);
        step('0, '0, 0, 0);
        chk("R8 ack memory dropped", {24'h0, req}, 32'h80);
        step('0, 8'h80, 0, 0);
        chk("R8 later ack releases", {24'h0, req}, 32'h00);

        phase = "R3";
        step('0, '0, 1, 32'h0000_0000);
        step(8'hFF, '0, 0, 0);
        chk("R3 disabled ignore", rd, 32'h0020_0000);
        chk("R3 no req", {24'h0, req}, 32'h0);

        phase = "R11";
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) mode = $urandom_range(0, 1);
            step($urandom, $urandom, ($urandom_range(0, 3) == 0), $urandom);
            chk("R11 spare bits", rd & 32'hFF00_FF00, 32'h0);
        end

        phase = "R10";
        step(8'hFF, '0, 1, 32'h0000_00FF);
        step(8'hFF, '0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid reset rd", rd, 32'h0);
        chk("R10 mid reset req", {24'h0, req}, 32'h0);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule